// File: doc/BRIEF.md
# Hitless Selectable Clock Divider Bank

This block takes one fast input clock and derives three banks of divided clocks, A, B and C, with four outputs each. Every bank has a two-bit ratio select that indexes its own irregular ratio table. A prescale select either uses those ratios as they are or doubles every one of them. All outputs are registered, so they change only on a rising input clock edge. Ratios are expressed in input clock cycles, and every ratio is even, so each output is high for exactly half of its period.

The selects may change at any time while the block runs. Each bank runs a small state machine with three states. `ST_LOAD` is the reset state. `ST_HIGH` drives the output high and `ST_LOW` drives it low. The transitions are: *start* (ST_LOAD to ST_HIGH, which captures the ratio), *half-done* (ST_HIGH to ST_LOW, taken when the high half has elapsed) and *wrap* (ST_LOW to ST_HIGH, taken when the period has ended). The wrap transition is the only place where a running bank reads its select inputs. Because of this, every output period is either a whole old period or a whole new one, and no period can come out shortened or stretched. An invert input flips outputs 2 and 3 of bank C. An active-low reset clears all state and holds all twelve outputs low.

Top module: `clkdiv_bank_top`

## Requirements
- R1: While `rst_ni` is low, all twelve outputs are low whatever the other inputs do. After release, every bank output rises on the first rising input clock edge.
- R2: With `pre_bypass_i` high, bank A divides by 2, 6, 4 and 12 for `sel_a_i` = 00, 01, 10 and 11.
- R3: With `pre_bypass_i` high, bank B divides by 2, 6, 4 and 10 for `sel_b_i` = 00, 01, 10 and 11.
- R4: With `pre_bypass_i` high, bank C divides by 8, 2, 6 and 4 for `sel_c_i` = 00, 01, 10 and 11.
- R5: With `pre_bypass_i` low, every bank's ratio is twice its table value.
- R6: Each output is high for exactly half of its period, counted in input clock cycles, starting at its rising edge.
- R7: A bank select that changes in the middle of a period takes effect only at the next rising edge of that bank's output. The running period finishes at the old ratio and the next period uses the new ratio, so no period is shorter than both ratios or longer than both.
- R8: A change of `pre_bypass_i` in the middle of a period follows the same rule as R7.
- R9: The four outputs of bank A are identical, as are the four outputs of bank B. Outputs 0 and 1 of bank C are identical, and outputs 2 and 3 of bank C equal them when `inv_c_i` is low.
- R10: When `inv_c_i` is high, `qc_o[3:2]` is the complement of `qc_o[1:0]`, starting at the next rising input clock edge. When `inv_c_i` is low, `qc_o[3:2]` follows `qc_o[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock that all outputs are divided from |
| rst_ni | input | 1 | Active-low asynchronous reset; holds all outputs low |
| pre_bypass_i | input | 1 | 1: use table ratios; 0: double every ratio |
| sel_a_i | input | 2 | Ratio select for bank A |
| sel_b_i | input | 2 | Ratio select for bank B |
| sel_c_i | input | 2 | Ratio select for bank C |
| inv_c_i | input | 1 | 1: invert bank C outputs 2 and 3 |
| qa_o | output | 4 | Bank A divided clocks |
| qb_o | output | 4 | Bank B divided clocks |
| qc_o | output | 4 | Bank C divided clocks; bits 3:2 optionally inverted |

## Verification
The bench measures the period and the high time of each bank, rise to rise, for all four codes with the prescaler bypassed and again with it doubling. Because the three tables differ, this separates a swapped table row from a missing doubling, and the high-time count shows any error in the half-point compare. A select change is injected a few cycles into a 12-cycle period, and another one cycle into a 2-cycle period. These show whether the running period is cut short or stretched, or whether the new ratio is applied one period late. A prescale toggle in the middle of a period checks the same capture point for the doubling path. Further runs check the invert pairing and a reset in the middle of a run, including the rising edge one cycle after release.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_e;

    localparam int NUM_BANKS = 3;
    localparam int BASE_W    = 5;

    // Undoubled ratio for a bank and select code.
    function automatic logic [BASE_W-1:0] base_ratio(input int bank, input logic [1:0] sel);
        logic [BASE_W-1:0] r;
        r = 5'd2;
        case (bank)
            0: case (sel)
                   2'b00: r = 5'd2;
                   2'b01: r = 5'd6;
                   2'b10: r = 5'd4;
                   default: r = 5'd12;
               endcase
            1: case (sel)
                   2'b00: r = 5'd2;
                   2'b01: r = 5'd6;
                   2'b10: r = 5'd4;
                   default: r = 5'd10;
               endcase
            default: case (sel)
                   2'b00: r = 5'd8;
                   2'b01: r = 5'd2;
                   2'b10: r = 5'd6;
                   default: r = 5'd4;
               endcase
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkdiv_ratio_sel.sv
module clkdiv_ratio_sel
    import clkdiv_pkg::*;
#(
    parameter int BANK  = 0,
    parameter int CNT_W = 6
) (
    input  logic [1:0]       sel_i,
    input  logic             pre_bypass_i,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] half_o
);

    logic [CNT_W-1:0] base;

    always_comb begin
        base     = CNT_W'(base_ratio(BANK, sel_i));
        period_o = pre_bypass_i ? base : (base << 1);
        half_o   = period_o >> 1;
    end

endmodule

// File: rtl/clkdiv_bank_fsm.sv
module clkdiv_bank_fsm
    import clkdiv_pkg::*;
#(
    parameter int BANK  = 0,
    parameter int CNT_W = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] sel_i,
    input  logic       pre_bypass_i,
    input  logic       inv_i,
    output logic       q_o,
    output logic       q_alt_o
);

    div_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] period_q, period_d;
    logic [CNT_W-1:0] half_q, half_d;
    logic [CNT_W-1:0] new_period, new_half;
    logic             high_d;

    clkdiv_ratio_sel #(.BANK(BANK), .CNT_W(CNT_W)) u_ratio (
        .sel_i        (sel_i),
        .pre_bypass_i (pre_bypass_i),
        .period_o     (new_period),
        .half_o       (new_half)
    );

    // Next-state logic: selects are read only on start and wrap.
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q + 1'b1;
        period_d = period_q;
        half_d   = half_q;
        unique case (state_q)
            ST_LOAD: begin
                state_d  = ST_HIGH;
                cnt_d    = '0;
                period_d = new_period;
                half_d   = new_half;
            end
            ST_HIGH: begin
                if (cnt_q == half_q - 1'b1) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (cnt_q == period_q - 1'b1) begin
                    state_d  = ST_HIGH;
                    cnt_d    = '0;
                    period_d = new_period;
                    half_d   = new_half;
                end
            end
            default: begin
                state_d = ST_LOAD;
                cnt_d   = '0;
            end
        endcase
    end

    assign high_d = (state_d == ST_HIGH);

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= ST_LOAD;
            cnt_q    <= '0;
            period_q <= '0;
            half_q   <= '0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            period_q <= period_d;
            half_q   <= half_d;
        end
    end

    // Output register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o     <= 1'b0;
            q_alt_o <= 1'b0;
        end else begin
            q_o     <= high_d;
            q_alt_o <= high_d ^ inv_i;
        end
    end

endmodule

// File: rtl/clkdiv_bank_top.sv
module clkdiv_bank_top
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pre_bypass_i,
    input  logic [1:0] sel_a_i,
    input  logic [1:0] sel_b_i,
    input  logic [1:0] sel_c_i,
    input  logic       inv_c_i,
    output logic [3:0] qa_o,
    output logic [3:0] qb_o,
    output logic [3:0] qc_o
);

    localparam int INV_BANK = NUM_BANKS - 1;

    logic [1:0]           sel_bus [NUM_BANKS];
    logic [NUM_BANKS-1:0] q_main;
    logic [NUM_BANKS-1:0] q_alt;

    assign sel_bus[0] = sel_a_i;
    assign sel_bus[1] = sel_b_i;
    assign sel_bus[2] = sel_c_i;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        clkdiv_bank_fsm #(.BANK(g), .CNT_W(CNT_W)) u_fsm (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .sel_i        (sel_bus[g]),
            .pre_bypass_i (pre_bypass_i),
            .inv_i        ((g == INV_BANK) ? inv_c_i : 1'b0),
            .q_o          (q_main[g]),
            .q_alt_o      (q_alt[g])
        );
    end

    assign qa_o = {{2{q_alt[0]}}, {2{q_main[0]}}};
    assign qb_o = {{2{q_alt[1]}}, {2{q_main[1]}}};
    assign qc_o = {{2{q_alt[2]}}, {2{q_main[2]}}};

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       inv_c,
    input logic [3:0] qa,
    input logic [3:0] qb,
    input logic [3:0] qc
);

    logic [2:0] q0;
    assign q0 = {qc[0], qb[0], qa[0]};

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |-> (qa == 4'h0 && qb == 4'h0 && qc == 4'h0));

    // R10
    inv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (qc[3:2] == ({2{$past(inv_c)}} ^ qc[1:0])));

    // R9
    pair_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qa[2] == qa[0]) && (qb[3] == qb[1]));

    for (genvar b = 0; b < 3; b++) begin : g_duty
        logic       prev_q;
        logic       full_q;
        logic [7:0] hi_q;
        logic [7:0] lo_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                full_q <= 1'b0;
                hi_q   <= '0;
                lo_q   <= '0;
            end else begin
                prev_q <= q0[b];
                if (q0[b]) begin
                    if (!prev_q) begin
                        hi_q <= 8'd1;
                        lo_q <= '0;
                    end else begin
                        hi_q <= hi_q + 8'd1;
                    end
                end else begin
                    lo_q <= lo_q + 8'd1;
                    if (prev_q) full_q <= 1'b1;
                end
            end
        end

        // R6
        duty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q0[b] && !prev_q && full_q) |-> (lo_q == hi_q));

        // R5
        high_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q0[b] |-> (hi_q <= 8'd12));
    end

endmodule

bind clkdiv_bank_top clkdiv_chk u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .inv_c (inv_c_i),
    .qa    (qa_o),
    .qb    (qb_o),
    .qc    (qc_o)
);

// File: tb/tb_clkdiv_bank_top.sv
`timescale 1ns/1ps
module tb_clkdiv_bank_top;

    logic       clk;
    logic       rst_n;
    logic       pre;
    logic [1:0] sel_a, sel_b, sel_c;
    logic       inv_c;
    logic [3:0] qa, qb, qc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    clkdiv_bank_top dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .pre_bypass_i (pre),
        .sel_a_i      (sel_a),
        .sel_b_i      (sel_b),
        .sel_c_i      (sel_c),
        .inv_c_i      (inv_c),
        .qa_o         (qa),
        .qb_o         (qb),
        .qc_o         (qc)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic int exp_ratio(input int b, input logic [1:0] s, input logic p);
        int tab_a [4] = '{2, 6, 4, 12};
        int tab_b [4] = '{2, 6, 4, 10};
        int tab_c [4] = '{8, 2, 6, 4};
        int r;
        if (b == 0) r = tab_a[s];
        else if (b == 1) r = tab_b[s];
        else r = tab_c[s];
        return p ? r : 2 * r;
    endfunction

    function automatic logic getbit(input int b);
        if (b == 0) return qa[0];
        if (b == 1) return qb[0];
        return qc[0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_sel(input int b, input logic [1:0] s);
        if (b == 0) sel_a = s;
        else if (b == 1) sel_b = s;
        else sel_c = s;
    endtask

    task automatic wait_rise(input int b);
        logic prev;
        prev = getbit(b);
        forever begin
            @(negedge clk);
            if (getbit(b) && !prev) return;
            prev = getbit(b);
        end
    endtask

    // Called just after a rise is observed; measures that period.
    task automatic run_period(input int b, input int chg, input logic [1:0] nsel,
                              input logic npre, output int per, output int hi);
        logic prev;
        per  = 1;
        hi   = 1;
        prev = 1'b1;
        forever begin
            if (per == chg) begin
                set_sel(b, nsel);
                pre = npre;
            end
            @(negedge clk);
            if (getbit(b) && !prev) return;
            per++;
            if (getbit(b)) hi++;
            prev = getbit(b);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        inv_c = 1'b1;
        repeat (3) @(negedge clk);
        // R1: all outputs low in reset even with invert high
        check(qa == 0 && qb == 0 && qc == 0, "R1", {qa, qb, qc}, 0);
        inv_c = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first rise on first edge after release
        check(qa[0] && qb[0] && qc[0], "R1", {qa[0], qb[0], qc[0]}, 7);
    endtask

    task automatic t_static;
        int per, hi;
        for (int p = 1; p >= 0; p--) begin
            for (int s = 0; s < 4; s++) begin
                pre   = p[0];
                sel_a = s[1:0];
                sel_b = s[1:0];
                sel_c = s[1:0];
                for (int b = 0; b < 3; b++) begin
                    wait_rise(b);
                    wait_rise(b);
                    run_period(b, 0, 2'b00, pre, per, hi);
                    // R2 R3 R4 R5: ratio per bank table and prescale
                    check(per == exp_ratio(b, s[1:0], p[0]),
                          b == 0 ? "R2/R5" : (b == 1 ? "R3/R5" : "R4/R5"),
                          per, exp_ratio(b, s[1:0], p[0]));
                    // R6: half duty
                    check(hi * 2 == per, "R6", hi, per / 2);
                end
                begin
                    bit ok;
                    ok = 1'b1;
                    for (int k = 0; k < 30; k++) begin
                        @(negedge clk);
                        if (qa != {4{qa[0]}} || qb != {4{qb[0]}} || qc != {4{qc[0]}}) ok = 1'b0;
                    end
                    // R9: bank outputs identical
                    check(ok, "R9", {qa, qb, qc}, 0);
                end
            end
        end
    endtask

    task automatic t_hitless_sel;
        int per, hi;
        pre   = 1'b1;
        sel_a = 2'b11;
        wait_rise(0);
        wait_rise(0);
        run_period(0, 3, 2'b00, 1'b1, per, hi);
        // R7: running 12-period is not cut short
        check(per == 12 && hi == 6, "R7", per, 12);
        run_period(0, 0, 2'b00, 1'b1, per, hi);
        // R7: new ratio from next boundary
        check(per == 2, "R7", per, 2);
        run_period(0, 1, 2'b11, 1'b1, per, hi);
        // R7: running 2-period is not stretched
        check(per == 2, "R7", per, 2);
        run_period(0, 0, 2'b11, 1'b1, per, hi);
        check(per == 12 && hi == 6, "R7", per, 12);
    endtask

    task automatic t_hitless_pre;
        int per, hi;
        pre   = 1'b1;
        sel_c = 2'b00;
        wait_rise(2);
        wait_rise(2);
        run_period(2, 5, 2'b00, 1'b0, per, hi);
        // R8: prescale change waits for boundary
        check(per == 8 && hi == 4, "R8", per, 8);
        run_period(2, 0, 2'b00, 1'b0, per, hi);
        check(per == 16 && hi == 8, "R8", per, 16);
        pre = 1'b1;
    endtask

    task automatic t_invert;
        bit ok;
        sel_c = 2'b10;
        inv_c = 1'b1;
        @(negedge clk);
        ok = 1'b1;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (qc[3:2] != ~qc[1:0]) ok = 1'b0;
        end
        // R10: inverted pair
        check(ok, "R10", qc, {~qc[1:0], qc[1:0]});
        inv_c = 1'b0;
        @(negedge clk);
        ok = 1'b1;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (qc[3:2] != qc[1:0]) ok = 1'b0;
        end
        // R10 R9: pair follows when invert low
        check(ok, "R10", qc, {qc[1:0], qc[1:0]});
    endtask

    task automatic t_reset_midrun;
        int per, hi;
        sel_a = 2'b01;
        wait_rise(0);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        // R1: asynchronous clear mid-run
        check(qa == 0 && qb == 0 && qc == 0, "R1", {qa, qb, qc}, 0);
        repeat (3) @(negedge clk);
        check(qa == 0 && qb == 0 && qc == 0, "R1", {qa, qb, qc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(qa[0] == 1'b1, "R1", qa[0], 1);
        run_period(0, 0, 2'b01, 1'b1, per, hi);
        // R2: ratio after restart
        check(per == 6 && hi == 3, "R2", per, 6);
    endtask

    initial begin
        rst_n = 1'b1;
        pre   = 1'b1;
        sel_a = 2'b00;
        sel_b = 2'b00;
        sel_c = 2'b00;
        inv_c = 1'b0;
        #2;
        rst_n = 1'b0;
        t_reset();
        t_static();
        t_hitless_sel();
        t_hitless_pre();
        t_invert();
        t_reset_midrun();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule